// File: doc/BRIEF.md
# Packed Integer Tile Multiply-Accumulate Unit

This block performs one step of a small tiled integer matrix multiply-accumulate. Three operand arrays arrive as flattened ports of 32-bit words: A, B and C. A and B may carry one signed 32-bit value, two signed 16-bit values or four signed 8-bit values in each word. A step byte picks which A row-block and which B column-block are used. For every output position (i, j), the unit forms the dot product of an A row and a B column. The dot product runs across K words and every packed lane. The unit adds this to the matching C word and writes each 32-bit sum into a 64-bit result slot.

A caller raises `start` for one cycle together with the format byte, the step byte and the operands. When the format pairing is legal, the unit captures everything, holds `busy` while it works, and pulses `done` a fixed number of cycles later. The results stay on `d_flat` until the next completion. An illegal pairing is refused at once: the unit pulses `err` and does not start.

Top module: `tile_mac_unit`

## Requirements
- R1: While `rst_n` is low and right after it, `busy`, `done` and `err` are 0 and `d_flat` is all zeros.
- R2: `fmt[3:0]` is the input element code: 1 means one signed 32-bit value per word, 2 means two signed 16-bit lanes, 3 means four signed 8-bit lanes. `fmt[7:4]` is the output code, and only 1 (signed 32-bit) is legal.
- R3: A start with any other code in either nibble raises `err` for exactly one cycle, in the cycle after the sampling edge. `busy` stays 0, no `done` follows, and `d_flat` keeps its value.
- R4: `step[3:0]` is the row-block index m and `step[7:4]` is the column-block index n. A rows begin at word (m mod A_SUBS)×A_BLK and B columns begin at word (n mod B_SUBS)×B_BLK. Word w of a flattened array occupies bits [32w+31:32w].
- R5: Result word i×N+j equals C[i×N+j] plus the sum, over z in 0..K-1 and every lane l, of the products of the sign-extended lanes of A[a_base+i×K+z] and B[b_base+j×K+z]. Lane l of width W occupies bits [W·l+W-1:W·l]. All arithmetic wraps modulo 2^32.
- R6: Each result occupies a 64-bit slot: bits [31:0] hold the 32-bit sum and bits [63:32] are 0xFFFFFFFF.
- R7: For an accepted start, `done` is high in the 6th cycle after the accepting edge. `busy` is 1 from the accepting edge until `done` rises, and it is 0 while `done` is high.
- R8: `done` lasts exactly one cycle, and `d_flat` changes only together with a `done` pulse.
- R9: A start raised while `busy` is 1 is ignored. It does not alter the running result, its timing, or the number of `done` pulses.
- R10: Operands, format and step are captured at acceptance. Changes on those inputs while `busy` is 1 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a tile step |
| fmt | input | 8 | Output code (high nibble), input element code (low nibble) |
| step | input | 8 | Column-block n (high nibble), row-block m (low nibble) |
| a_flat | input | 256 | A operand words, A_SUBS×A_BLK words |
| b_flat | input | 256 | B operand words, B_SUBS×B_BLK words |
| c_flat | input | 128 | C accumulator words, M×N words |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an illegal format pairing |
| d_flat | output | 256 | M×N boxed 64-bit results |

## Verification
Random words are run through each of the three element widths. Because the same bit pattern yields different sums as one, two or four signed lanes, this exposes lane slicing and sign-extension faults. Large 32-bit operands force wrap-around. Step values of 0x00, 0x11, 0x10 and 0x23 separate the row-block and column-block offsets, the nibble order and the modulo on an index above the block count. Illegal pairings in each nibble, a start during busy, and operand changes after acceptance each show whether the unit refuses, ignores, or captures as required.

// File: rtl/tile_mac_unit.sv
module tile_mac_unit #(
  parameter int M       = 2,
  parameter int N       = 2,
  parameter int K       = 2,
  parameter int A_SUBS  = 2,
  parameter int B_SUBS  = 2,
  parameter int A_BLK   = M * K,
  parameter int B_BLK   = N * K,
  parameter int LATENCY = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [7:0]                      fmt,
  input  logic [7:0]                      step,
  input  logic [A_SUBS*A_BLK*32-1:0]      a_flat,
  input  logic [B_SUBS*B_BLK*32-1:0]      b_flat,
  input  logic [M*N*32-1:0]               c_flat,
  output logic                            busy,
  output logic                            done,
  output logic                            err,
  output logic [M*N*64-1:0]               d_flat
);

  localparam int A_BITS = A_SUBS * A_BLK * 32;
  localparam int B_BITS = B_SUBS * B_BLK * 32;
  localparam int C_WORDS = M * N;
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
  localparam logic [3:0] CODE_I32 = 4'h1;
  localparam logic [3:0] CODE_I16 = 4'h2;
  localparam logic [3:0] CODE_I8  = 4'h3;

  logic              busy_q, done_q, err_q;
  logic [CW-1:0]     cnt_q;
  logic [A_BITS-1:0] a_q;
  logic [B_BITS-1:0] b_q;
  logic [C_WORDS*32-1:0] c_q;
  logic [1:0]        mode_q;
  logic [3:0]        m_q, n_q;
  logic [C_WORDS*64-1:0] d_q;
  logic [C_WORDS*32-1:0] sums;
  logic [C_WORDS*64-1:0] boxed;

  wire in_ok  = (fmt[3:0] == CODE_I32) || (fmt[3:0] == CODE_I16) || (fmt[3:0] == CODE_I8);
  wire fmt_ok = (fmt[7:4] == CODE_I32) && in_ok;
  wire accept = start && !busy_q;
  wire [1:0] mode_in = (fmt[3:0] == CODE_I16) ? 2'd1 : (fmt[3:0] == CODE_I8) ? 2'd2 : 2'd0;

  function automatic logic [31:0] word_mac(input logic [31:0] acc, input logic [31:0] x,
                                           input logic [31:0] y, input logic [1:0] md);
    logic [31:0] r;
    r = acc;
    case (md)
      2'd1: for (int l = 0; l < 2; l++)
              r = r + {{16{x[16*l+15]}}, x[16*l +: 16]} * {{16{y[16*l+15]}}, y[16*l +: 16]};
      2'd2: for (int l = 0; l < 4; l++)
              r = r + {{24{x[8*l+7]}}, x[8*l +: 8]} * {{24{y[8*l+7]}}, y[8*l +: 8]};
      default: r = r + x * y;
    endcase
    return r;
  endfunction

  always_comb begin : calc
    logic [31:0] acc;
    int a_base, b_base;
    sums   = '0;
    a_base = int'(32'(m_q) % A_SUBS) * A_BLK;
    b_base = int'(32'(n_q) % B_SUBS) * B_BLK;
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < N; j++) begin
        acc = c_q[32*(i*N+j) +: 32];
        for (int z = 0; z < K; z++)
          acc = word_mac(acc, a_q[32*(a_base+i*K+z) +: 32], b_q[32*(b_base+j*K+z) +: 32], mode_q);
        sums[32*(i*N+j) +: 32] = acc;
      end
    end
  end

  for (genvar w = 0; w < C_WORDS; w++) begin : g_box
    assign boxed[64*w +: 64] = {32'hFFFF_FFFF, sums[32*w +: 32]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      mode_q <= 2'd0;
      m_q    <= '0;
      n_q    <= '0;
      d_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (fmt_ok) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(LATENCY - 1);
          a_q    <= a_flat;
          b_q    <= b_flat;
          c_q    <= c_flat;
          mode_q <= mode_in;
          m_q    <= step[3:0];
          n_q    <= step[7:4];
        end else begin
          err_q <= 1'b1;
        end
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          d_q    <= boxed;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign err    = err_q;
  assign d_flat = d_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R3
  done_err_chk: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(d_flat));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(busy) && !busy));

  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);

  for (genvar w = 0; w < C_WORDS; w++) begin : g_box_chk
    // R6
    box_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (d_flat[64*w+32 +: 32] == 32'hFFFF_FFFF));
  end

endmodule

// File: tb/tile_mac_unit_tb.sv
module tile_mac_unit_tb;
  localparam int AW = 8, BW = 8, CWD = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] fmt_i = 0, step_i = 0;
  logic [AW*32-1:0] a_flat;
  logic [BW*32-1:0] b_flat;
  logic [CWD*32-1:0] c_flat;
  logic busy, done, err;
  logic [CWD*64-1:0] d_flat;

  logic [31:0] A [AW];
  logic [31:0] B [BW];
  logic [31:0] C [CWD];
  logic [63:0] exp_d [CWD];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int w = 0; w < AW; w++) a_flat[32*w +: 32] = A[w];
    for (int w = 0; w < BW; w++) b_flat[32*w +: 32] = B[w];
    for (int w = 0; w < CWD; w++) c_flat[32*w +: 32] = C[w];
  end

  tile_mac_unit u_dut (.clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt_i), .step(step_i),
    .a_flat(a_flat), .b_flat(b_flat), .c_flat(c_flat), .busy(busy), .done(done), .err(err),
    .d_flat(d_flat));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] model(input int i, input int j, input logic [3:0] it,
                                        input logic [7:0] s);
    int ab, bb;
    logic [31:0] acc, x, y;
    ab  = (int'(s[3:0]) % 2) * 4;
    bb  = (int'(s[7:4]) % 2) * 4;
    acc = C[i*2+j];
    for (int z = 0; z < 2; z++) begin
      x = A[ab + i*2 + z];
      y = B[bb + j*2 + z];
      if (it == 4'h1) acc = acc + x * y;
      else if (it == 4'h2) begin
        for (int l = 0; l < 2; l++) begin
          logic signed [15:0] hx, hy;
          hx = x[16*l +: 16]; hy = y[16*l +: 16];
          acc = acc + 32'(int'(hx) * int'(hy));
        end
      end else begin
        for (int l = 0; l < 4; l++) begin
          logic signed [7:0] bx, by;
          bx = x[8*l +: 8]; by = y[8*l +: 8];
          acc = acc + 32'(int'(bx) * int'(by));
        end
      end
    end
    return acc;
  endfunction

  task automatic fill_random();
    for (int w = 0; w < AW; w++) A[w] = $urandom;
    for (int w = 0; w < BW; w++) B[w] = $urandom;
    for (int w = 0; w < CWD; w++) C[w] = $urandom;
  endtask

  task automatic make_exp(input logic [7:0] f, input logic [7:0] s);
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        exp_d[i*2+j] = {32'hFFFF_FFFF, model(i, j, f[3:0], s)};
  endtask

  task automatic check_d(input string tag);
    for (int w = 0; w < CWD; w++) chk(tag, d_flat[64*w +: 64], exp_d[w]);
  endtask

  // Issues a start; returns the sample index at which done was seen (0 if never).
  task automatic run_op(input logic [7:0] f, input logic [7:0] s, output int lat);
    logic busy_ok;
    busy_ok = 1;
    @(negedge clk); fmt_i = f; step_i = s; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    lat = 0;
    for (int k = 1; k <= 12; k++) begin
      if (!busy) busy_ok = 0;
      @(posedge clk); @(negedge clk);
      if (done) begin lat = k; break; end
    end
    chk("R7 busy during run", {63'd0, busy_ok}, 64'd1);
    chk("R7 busy low at done", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", {63'd0, busy}, 64'd0);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 err", {63'd0, err}, 64'd0);
    chk("R1 d_flat", {63'd0, d_flat == '0}, 64'd1);
  endtask

  task automatic t_format(input logic [7:0] f, input logic [7:0] s, input string tag);
    int lat;
    fill_random();
    make_exp(f, s);
    run_op(f, s, lat);
    chk({"R7 latency ", tag}, 64'(lat), 64'd6);
    check_d({"R5 R6 ", tag});
  endtask

  task automatic t_wrap();
    int lat;
    fill_random();
    A[0] = 32'h7FFF_FFFF; A[1] = 32'h8000_0001; B[0] = 32'h7FFF_FFFF; B[1] = 32'hFFFF_FFFF;
    C[0] = 32'hFFFF_FFF0;
    make_exp(8'h11, 8'h00);
    run_op(8'h11, 8'h00, lat);
    check_d("R5 wrap i32");
  endtask

  task automatic t_bad(input logic [7:0] f, input string tag);
    logic [CWD*64-1:0] saved;
    logic seen_done;
    saved = d_flat;
    seen_done = 0;
    @(negedge clk); fmt_i = f; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    chk({"R3 err pulse ", tag}, {63'd0, err}, 64'd1);
    chk({"R3 not busy ", tag}, {63'd0, busy}, 64'd0);
    @(posedge clk); @(negedge clk);
    chk({"R3 err one cycle ", tag}, {63'd0, err}, 64'd0);
    for (int k = 0; k < 8; k++) begin
      if (done) seen_done = 1;
      @(posedge clk); @(negedge clk);
    end
    chk({"R3 no done ", tag}, {63'd0, seen_done}, 64'd0);
    chk({"R3 d kept ", tag}, {63'd0, d_flat == saved}, 64'd1);
  endtask

  task automatic t_busy_start();
    int lat, extra;
    logic [CWD*64-1:0] saved;
    fill_random();
    make_exp(8'h12, 8'h10);
    @(negedge clk); fmt_i = 8'h12; step_i = 8'h10; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    lat = 0;
    for (int k = 1; k <= 12; k++) begin
      if (k == 2) begin fmt_i = 8'h13; step_i = 8'h01; start = 1; end
      if (k == 4) start = 0;
      @(posedge clk); @(negedge clk);
      if (done) begin lat = k; break; end
    end
    start = 0;
    chk("R9 latency unchanged", 64'(lat), 64'd6);
    check_d("R9 result unchanged");
    saved = d_flat;
    @(posedge clk); @(negedge clk);
    chk("R8 done one cycle", {63'd0, done}, 64'd0);
    extra = 0;
    for (int k = 0; k < 8; k++) begin
      if (done) extra++;
      @(posedge clk); @(negedge clk);
    end
    chk("R9 no second done", 64'(extra), 64'd0);
    chk("R8 d stable", {63'd0, d_flat == saved}, 64'd1);
  endtask

  task automatic t_capture();
    int lat;
    fill_random();
    make_exp(8'h13, 8'h01);
    @(negedge clk); fmt_i = 8'h13; step_i = 8'h01; start = 1;
    @(posedge clk); @(negedge clk); start = 0;
    fill_random(); fmt_i = 8'h11; step_i = 8'h00;
    lat = 0;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); @(negedge clk);
      if (done) begin lat = k; break; end
    end
    chk("R10 latency", 64'(lat), 64'd6);
    check_d("R10 captured operands");
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fill_random();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_format(8'h11, 8'h00, "R2 i32 step00");
    t_format(8'h12, 8'h11, "R2 i16 step11");
    t_format(8'h13, 8'h10, "R4 i8 step10");
    t_format(8'h13, 8'h23, "R4 i8 step23 modulo");
    t_format(8'h12, 8'h01, "R4 i16 step01");
    t_wrap();
    t_bad(8'h21, "out code 2");
    t_bad(8'h14, "in code 4");
    t_bad(8'h10, "in code 0");
    t_busy_start();
    t_capture();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule